// File: doc/BRIEF.md
# Carry-Completion Detecting Adder

This block adds two WIDTH-bit operands and a carry-in. It models a self-timed ripple adder as a clocked circuit. Every carry position holds a two-rail code that is either unresolved or resolved to a known value. One clock advances the resolution front by one position. A generate or annihilate bit settles its outgoing carry immediately. A propagate bit waits for the carry below it and then copies it.

The block raises its done flag on the step in which every position, including the carry-out, holds a resolved code. The latency therefore follows the longest run of propagate bits in the actual operands rather than the full word width. The step count is reported alongside the result. A caller pulses `start` with the operands present, waits for `done`, and then reads `sum`, `carry_out` and `cycles`. These outputs hold until the next start.

Top module: `cca_adder`

## Requirements
- R1: When `done` is high, `{carry_out, sum}` equals `op_a + op_b + carry_in` of the operands captured at the last start.
- R2: Each carry position holds a two-rail code: (high rail, low rail) = (0,0) unresolved, (1,0) carry one, (0,1) carry zero. The code (1,1) never occurs. `carry_out` is the value of the resolved code at position WIDTH.
- R3: Every operand bit falls into exactly one class: generate (both bits 1), propagate (bits differ), annihilate (both bits 0). A generate or annihilate bit resolves its outgoing carry in the first step. With no propagate bits at all, `cycles` is 1.
- R4: A propagate bit takes on the resolved code of the carry below it one step after that carry resolves. A run of k propagate bits that does not start at bit 0 therefore needs k+1 steps.
- R5: The carry into bit 0 is resolved from the start pulse onward. A run of k propagate bits starting at bit 0 needs k steps, so all-propagate operands give `cycles` = WIDTH.
- R6: In the cycle after a clock edge that samples `start` high, `done` is 0 and `cycles` is 0. After that, exactly one propagation step happens per clock and `cycles` counts the steps.
- R7: `done` rises only when every carry position is resolved. `done`, `sum`, `carry_out` and `cycles` then stay unchanged until the next start.
- R8: A start that arrives while a computation is running discards that computation. The block clears its carries and computes the new operands from scratch.
- R9: After reset, `done`, `cycles`, `sum` and `carry_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | One-cycle pulse that captures the operands and begins a computation |
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Sum bits; valid while `done` is high, 0 otherwise |
| carry_out | output | 1 | Carry out of the top bit; valid while `done` is high |
| done | output | 1 | All carry positions resolved |
| cycles | output | $clog2(WIDTH+1) | Propagation steps used by the latest computation |

## Verification
Operands with no propagate bit separate a correct one-step resolution from a design that always ripples. All-propagate operands with both carry-in values exercise the full-width chain and tell whether the carry-in is treated as already resolved. Operands with a single propagate run placed either at bit 0 or in the middle of the word distinguish the k and k+1 step counts. A stream of pseudo-random operand pairs checks sum and step count against a run-length computation made in the bench. A restart issued mid-chain and a hold window after completion confirm that old state is discarded and that finished results do not drift.

// File: rtl/cca_pkg.sv
package cca_pkg;
  // Two-rail carry code: {hi, lo}
  typedef struct packed {
    logic hi;
    logic lo;
  } dr_t;

  localparam dr_t DR_OPEN = '{hi: 1'b0, lo: 1'b0};
  localparam dr_t DR_ONE  = '{hi: 1'b1, lo: 1'b0};
  localparam dr_t DR_ZERO = '{hi: 1'b0, lo: 1'b1};

  // Encode a known carry value as a resolved two-rail code
  function automatic dr_t dr_from_bit(input logic v);
    dr_t r;
    r.hi = v;
    r.lo = ~v;
    return r;
  endfunction
endpackage

// File: rtl/cca_classify.sv
module cca_classify #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  output logic [WIDTH-1:0] gen,
  output logic [WIDTH-1:0] prop,
  output logic [WIDTH-1:0] kill
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_comb begin
      gen[i]  = opa[i] & opb[i];
      prop[i] = opa[i] ^ opb[i];
      kill[i] = ~(opa[i] | opb[i]);
    end
  end
endmodule

// File: rtl/cca_carry_step.sv
module cca_carry_step
  import cca_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] gen,
  input  logic [WIDTH-1:0] kill,
  input  logic [WIDTH:0]   cur_hi,
  input  logic [WIDTH:0]   cur_lo,
  output logic [WIDTH:0]   nxt_hi,
  output logic [WIDTH:0]   nxt_lo
);
  // Position 0 is the carry-in: already resolved, never changes
  always_comb begin
    nxt_hi[0] = cur_hi[0];
    nxt_lo[0] = cur_lo[0];
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    dr_t below;
    dr_t above;
    always_comb begin
      below = '{hi: cur_hi[i], lo: cur_lo[i]};
      if (gen[i]) begin
        above = DR_ONE;
      end else if (kill[i]) begin
        above = DR_ZERO;
      end else begin
        above = below;
      end
      nxt_hi[i+1] = above.hi;
      nxt_lo[i+1] = above.lo;
    end
  end
endmodule

// File: rtl/cca_done_detect.sv
module cca_done_detect #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH:0] rail_hi,
  input  logic [WIDTH:0] rail_lo,
  output logic           all_resolved
);
  logic [WIDTH:0] pos_ok;

  for (genvar i = 0; i <= WIDTH; i++) begin : g_pos
    always_comb pos_ok[i] = rail_hi[i] | rail_lo[i];
  end

  always_comb all_resolved = &pos_ok;
endmodule

// File: rtl/cca_adder.sv
module cca_adder
  import cca_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int CNT_W = $clog2(WIDTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             carry_in,
  output logic [WIDTH-1:0] sum,
  output logic             carry_out,
  output logic             done,
  output logic [CNT_W-1:0] cycles
);
  // Reset synchronizer: asserts at once, releases after two edges
  logic [1:0] rst_sync_q;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  always_comb core_rst_n = rst_sync_q[1];

  // State
  logic [WIDTH-1:0] opa_q, opa_d;
  logic [WIDTH-1:0] opb_q, opb_d;
  logic [WIDTH:0]   hi_q, hi_d;
  logic [WIDTH:0]   lo_q, lo_d;
  logic             busy_q, busy_d;
  logic             done_q, done_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             state_en;

  // Datapath
  logic [WIDTH-1:0] gen, prop, kill;
  logic [WIDTH:0]   step_hi, step_lo;
  logic             step_all;
  dr_t              cin_code;

  cca_classify #(.WIDTH(WIDTH)) u_classify (
    .opa  (opa_q),
    .opb  (opb_q),
    .gen  (gen),
    .prop (prop),
    .kill (kill)
  );

  cca_carry_step #(.WIDTH(WIDTH)) u_step (
    .gen    (gen),
    .kill   (kill),
    .cur_hi (hi_q),
    .cur_lo (lo_q),
    .nxt_hi (step_hi),
    .nxt_lo (step_lo)
  );

  cca_done_detect #(.WIDTH(WIDTH)) u_detect (
    .rail_hi      (step_hi),
    .rail_lo      (step_lo),
    .all_resolved (step_all)
  );

  // Next-state logic
  always_comb begin
    cin_code = dr_from_bit(carry_in);
    state_en = start | busy_q;
    opa_d    = opa_q;
    opb_d    = opb_q;
    hi_d     = hi_q;
    lo_d     = lo_q;
    busy_d   = busy_q;
    done_d   = done_q;
    cnt_d    = cnt_q;
    if (start) begin
      opa_d     = op_a;
      opb_d     = op_b;
      hi_d      = '0;
      lo_d      = '0;
      hi_d[0]   = cin_code.hi;
      lo_d[0]   = cin_code.lo;
      busy_d    = 1'b1;
      done_d    = 1'b0;
      cnt_d     = '0;
    end else if (busy_q) begin
      hi_d  = step_hi;
      lo_d  = step_lo;
      cnt_d = cnt_q + CNT_W'(1);
      if (step_all) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  // Registers with explicit enable
  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      opa_q  <= '0;
      opb_q  <= '0;
      hi_q   <= '0;
      lo_q   <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else if (state_en) begin
      opa_q  <= opa_d;
      opb_q  <= opb_d;
      hi_q   <= hi_d;
      lo_q   <= lo_d;
      busy_q <= busy_d;
      done_q <= done_d;
      cnt_q  <= cnt_d;
    end
  end

  // Outputs: sum bits use the resolved carry value into each bit
  always_comb begin
    done      = done_q;
    cycles    = cnt_q;
    sum       = done_q ? (prop ^ hi_q[WIDTH-1:0]) : '0;
    carry_out = done_q & hi_q[WIDTH];
  end
endmodule

// File: rtl/cca_adder_checks.sv
module cca_adder_checks #(
  parameter int WIDTH = 8,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             done,
  input logic [CNT_W-1:0] cycles,
  input logic [WIDTH-1:0] sum,
  input logic             carry_out,
  input logic [WIDTH-1:0] gen,
  input logic [WIDTH-1:0] prop,
  input logic [WIDTH-1:0] kill,
  input logic [WIDTH:0]   rail_hi,
  input logic [WIDTH:0]   rail_lo
);
  AST_NO_ILLEGAL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (rail_hi & rail_lo) == '0); // R2

  AST_CLASS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    ((gen | prop | kill) == '1) && (((gen & prop) | (gen & kill) | (prop & kill)) == '0)); // R3

  AST_RESOLVED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (((rail_hi & $past(rail_hi)) == $past(rail_hi))
             && ((rail_lo & $past(rail_lo)) == $past(rail_lo)))); // R4

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!done && cycles == '0)); // R6

  AST_DONE_ALL_RESOLVED: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((rail_hi | rail_lo) == '1)); // R7

  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(sum) && $stable(cycles) && $stable(carry_out))); // R7

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cycles <= CNT_W'(WIDTH)); // R5
endmodule

bind cca_adder cca_adder_checks #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_checks (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .done      (done),
  .cycles    (cycles),
  .sum       (sum),
  .carry_out (carry_out),
  .gen       (gen),
  .prop      (prop),
  .kill      (kill),
  .rail_hi   (hi_q),
  .rail_lo   (lo_q)
);

// File: tb/cca_adder_test.sv
`timescale 1ns/1ps
module cca_adder_test;
  localparam int W  = 8;
  localparam int CW = $clog2(W + 1);

  logic          clk;
  logic          rst_n;
  logic          start;
  logic [W-1:0]  op_a, op_b;
  logic          carry_in;
  logic [W-1:0]  sum;
  logic          carry_out;
  logic          done;
  logic [CW-1:0] cycles;

  int n_checks = 0;
  int n_fail   = 0;
  logic [31:0] rng = 32'h1234_5678;

  cca_adder #(.WIDTH(W)) uut (
    .clk (clk), .rst_n (rst_n), .start (start),
    .op_a (op_a), .op_b (op_b), .carry_in (carry_in),
    .sum (sum), .carry_out (carry_out), .done (done), .cycles (cycles)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Expected step count from the propagate-run rule (R4, R5)
  function automatic int exp_steps(input logic [W-1:0] a, input logic [W-1:0] b);
    int best = 1;
    int len  = 0;
    bit lead = 1'b1;
    for (int i = 0; i < W; i++) begin
      if (a[i] ^ b[i]) begin
        int v;
        len++;
        v = lead ? len : len + 1;
        if (v > best) best = v;
      end else begin
        len  = 0;
        lead = 1'b0;
      end
    end
    return best;
  endfunction

  task automatic pulse_start(input logic [W-1:0] a, input logic [W-1:0] b, input logic ci);
    @(negedge clk);
    op_a = a; op_b = b; carry_in = ci; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R6 done cleared after start", int'(done), 0);
    check("R6 cycles cleared after start", int'(cycles), 0);
  endtask

  task automatic finish_and_check(input logic [W-1:0] a, input logic [W-1:0] b,
                                  input logic ci, input string tag);
    int waited = 0;
    int exp_k  = exp_steps(a, b);
    logic [W:0] total = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci};
    while (!done && waited < 40) begin
      @(negedge clk);
      waited++;
    end
    check({"R7 done after expected steps ", tag}, waited, exp_k);
    check({"R1 sum ", tag}, int'(sum), int'(total[W-1:0]));
    check({"R2 carry_out ", tag}, int'(carry_out), int'(total[W]));
    check({"R4 cycles ", tag}, int'(cycles), exp_k);
  endtask

  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic ci, input string tag);
    pulse_start(a, b, ci);
    finish_and_check(a, b, ci, tag);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start = 1'b0; op_a = '0; op_b = '0; carry_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 done at reset", int'(done), 0);
    check("R9 cycles at reset", int'(cycles), 0);
    check("R9 sum at reset", int'(sum), 0);
    check("R9 carry_out at reset", int'(carry_out), 0);
  endtask

  task automatic t_no_propagate();
    run_op(8'hA5, 8'hA5, 1'b0, "gen/kill only");
    check("R3 one step", int'(cycles), 1);
    run_op(8'hFF, 8'hFF, 1'b1, "all generate");
    check("R3 one step all generate", int'(cycles), 1);
    run_op(8'h00, 8'h00, 1'b1, "all annihilate");
    check("R3 carry-out zero", int'(carry_out), 0);
  endtask

  task automatic t_all_propagate();
    run_op(8'hF0, 8'h0F, 1'b1, "all propagate ci=1");
    check("R5 full chain steps", int'(cycles), W);
    check("R5 wrap to zero", int'(sum), 0);
    run_op(8'h55, 8'hAA, 1'b0, "all propagate ci=0");
    check("R5 full chain steps ci=0", int'(cycles), W);
  endtask

  task automatic t_runs();
    // run of 3 starting at bit 0, rest generate: 3 steps
    run_op(8'b1111_1010, 8'b1111_1101, 1'b1, "leading run");
    check("R5 leading run of 3", int'(cycles), 3);
    // generate at bit 1, run of 4 at bits 2..5: 5 steps
    run_op(8'b0011_1110, 8'b0000_0010, 1'b0, "inner run");
    check("R4 inner run of 4", int'(cycles), 5);
  endtask

  task automatic t_hold();
    logic [W-1:0] s0;
    logic [CW-1:0] k0;
    logic c0;
    run_op(8'h6C, 8'h39, 1'b1, "hold base");
    s0 = sum; k0 = cycles; c0 = carry_out;
    op_a = 8'h01; op_b = 8'hFE; carry_in = 1'b0;
    repeat (6) @(negedge clk);
    check("R7 done held", int'(done), 1);
    check("R7 sum held", int'(sum), int'(s0));
    check("R7 cycles held", int'(cycles), int'(k0));
    check("R7 carry_out held", int'(carry_out), int'(c0));
  endtask

  task automatic t_restart();
    pulse_start(8'hF0, 8'h0F, 1'b1);
    repeat (2) @(negedge clk);
    check("R8 still busy before restart", int'(done), 0);
    pulse_start(8'h81, 8'h03, 1'b0);
    finish_and_check(8'h81, 8'h03, 1'b0, "after restart");
    check("R8 new operands only", int'(sum), 8'h84);
  endtask

  task automatic t_random();
    for (int n = 0; n < 300; n++) begin
      logic [W-1:0] a, b;
      rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
      a = rng[7:0];
      b = rng[15:8];
      run_op(a, b, rng[16], "random");
    end
  endtask

  initial begin
    #60000;
    n_fail++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_no_propagate();
    t_all_propagate();
    t_runs();
    t_hold();
    t_restart();
    t_random();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule